// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short, arbitrary transaction on a single-lane SPI flash bus. Software fills a bank of six transmit byte registers with the opcode, the address bytes (most significant first), any dummy bytes (written as 0x00) and any write data. It then writes the total transfer length, in bits, and sets the start bit in the command register. The block drops chip select, clocks the bits out on MOSI in SPI mode 0 and shifts MISO into a chain of ten receive byte registers. When the count is reached it raises chip select, waits at least one SCK period and clears the start bit. Software polls that bit to learn the transfer has finished.

The transmit bank is consumed from the highest index downwards: index 5 leaves the wire first. Received bytes land so that the last byte sits at receive index 0 and earlier bytes sit at higher indices. Software therefore reads the response in reverse index order. The opcode, address and dummy bytes together may not exceed six. If they use all six, no data phase can follow. SCK runs at half the system clock.

Top module: `spi_cmd_shifter`

## Requirements
- R1: Transmit registers sit at addresses 0 to 5 (address = bank index). Each reads back the last byte written to it. All of them, and the bit count register, read 0 after reset.
- R2: After reset, chip select is high, SCK is low and the command register (address 7) reads 0. Writing address 7 with bit 0 set starts a transfer from idle. Bit 0 of address 7 then reads 1 until the transfer is complete.
- R3: The bit count register at address 6 holds N. A transfer with N greater than 0 holds chip select low throughout and gives exactly N rising SCK edges, all while chip select is low. Chip select falls exactly once per transfer.
- R4: MOSI carries bank index 5 first, then indices 4 down to 0, each byte most significant bit first. Every bit past the 48th is 0.
- R5: SPI mode 0 is used. SCK is low whenever chip select is high. MOSI changes only while SCK falls. MISO is sampled at each rising SCK edge.
- R6: Receive bytes read at addresses 8 to 17, index k at address 8+k. The last bit received is bit 0 of index 0, and earlier bits fill upwards. Bits older than the last 80 are dropped. All receive bytes are cleared when a transfer starts.
- R7: After the last bit, chip select is high for at least two clock cycles (one SCK period) before the start bit reads 0.
- R8: Writing the start bit while a transfer is in progress is ignored. The running transfer keeps its bit count and is not restarted.
- R9: Starting with a bit count of 0 asserts no chip select and produces no SCK edge. The start bit clears within a few cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume the flash changes MISO only after a falling SCK edge. They also assume software writes no register in the same cycle as reset. The bench slave model moves MISO on each falling SCK edge and presents its first bit before chip select falls. All register writes happen at the falling system clock edge, well after reset has been released. A second start request is issued only in mid-transfer, so the restart-protection check sees a genuine overlap.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int NUM_TX   = 6;
    localparam int NUM_RX   = 10;
    localparam int CNT_W    = 8;
    localparam int GAP_CYC  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic mosi;
    } spi_pins_t;

    function automatic int cnt_addr(input int ntx);
        return ntx;
    endfunction

    function automatic int cmd_addr(input int ntx);
        return ntx + 1;
    endfunction

    function automatic int rx_base(input int ntx);
        return ntx + 2;
    endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int N_TX   = NUM_TX,
    parameter int N_RX   = NUM_RX,
    parameter int C_W    = CNT_W,
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 busy,
    input  logic [8*N_RX-1:0]    rx_flat,
    output logic [8*N_TX-1:0]    tx_flat,
    output logic [C_W-1:0]       bit_cnt,
    output logic                 start_req
);
    localparam int A_CNT = cnt_addr(N_TX);
    localparam int A_CMD = cmd_addr(N_TX);
    localparam int A_RX  = rx_base(N_TX);

    logic [7:0] tx_q [N_TX];

    genvar gi;
    generate
        for (gi = 0; gi < N_TX; gi++) begin : g_tx
            always_ff @(posedge clk) begin
                if (rst) begin
                    tx_q[gi] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(gi)) begin
                    tx_q[gi] <= wr_data;
                end
            end
            assign tx_flat[8*gi +: 8] = tx_q[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_CNT)) begin
            bit_cnt <= C_W'(wr_data);
        end
    end

    assign start_req = wr_en && (wr_addr == ADDR_W'(A_CMD)) && wr_data[0];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_TX; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = tx_q[i];
        end
        if (rd_addr == ADDR_W'(A_CNT)) rd_data = 8'(bit_cnt);
        if (rd_addr == ADDR_W'(A_CMD)) rd_data = {7'd0, busy};
        for (int k = 0; k < N_RX; k++) begin
            if (rd_addr == ADDR_W'(A_RX + k)) rd_data = rx_flat[8*k +: 8];
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int N_TX  = NUM_TX,
    parameter int N_RX  = NUM_RX,
    parameter int C_W   = CNT_W,
    parameter int GAP_N = GAP_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_req,
    input  logic [8*N_TX-1:0]    tx_flat,
    input  logic [C_W-1:0]       bit_cnt,
    input  logic                 miso,
    output spi_pins_t            pins,
    output logic                 busy,
    output logic [8*N_RX-1:0]    rx_flat
);
    localparam int TXW = 8 * N_TX;
    localparam int RXW = 8 * N_RX;
    localparam int GW  = $clog2(GAP_N + 1);

    eng_state_e     state;
    logic           phase;
    logic           sck_q;
    logic [TXW-1:0] tx_sr;
    logic [RXW-1:0] rx_sr;
    logic [C_W-1:0] remain;
    logic [GW-1:0]  gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= 1'b0;
            sck_q   <= 1'b0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            remain  <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        tx_sr   <= tx_flat;
                        rx_sr   <= '0;
                        remain  <= bit_cnt;
                        phase   <= 1'b0;
                        sck_q   <= 1'b0;
                        gap_cnt <= '0;
                        state   <= (bit_cnt == '0) ? ST_GAP : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!phase) begin
                        sck_q <= 1'b1;
                        phase <= 1'b1;
                        rx_sr <= {rx_sr[RXW-2:0], miso};
                    end else begin
                        sck_q  <= 1'b0;
                        phase  <= 1'b0;
                        tx_sr  <= {tx_sr[TXW-2:0], 1'b0};
                        remain <= remain - 1'b1;
                        if (remain == C_W'(1)) begin
                            state   <= ST_GAP;
                            gap_cnt <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GW'(GAP_N - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.cs_n = (state != ST_XFER);
        pins.sck  = sck_q;
        pins.mosi = (state == ST_XFER) ? tx_sr[TXW-1] : 1'b0;
    end

    assign busy    = (state != ST_IDLE);
    assign rx_flat = rx_sr;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int N_TX   = NUM_TX,
    parameter int N_RX   = NUM_RX,
    parameter int C_W    = CNT_W,
    parameter int GAP_N  = GAP_CYC,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [8*N_TX-1:0] tx_flat;
    logic [8*N_RX-1:0] rx_flat;
    logic [C_W-1:0]    bit_cnt;
    logic              start_req;
    logic              busy_w;
    spi_pins_t         pins;

    spi_cmd_regs #(
        .N_TX(N_TX), .N_RX(N_RX), .C_W(C_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy_w), .rx_flat(rx_flat),
        .tx_flat(tx_flat), .bit_cnt(bit_cnt), .start_req(start_req)
    );

    spi_cmd_engine #(
        .N_TX(N_TX), .N_RX(N_RX), .C_W(C_W), .GAP_N(GAP_N)
    ) eng_i (
        .clk(clk), .rst(rst),
        .start_req(start_req), .tx_flat(tx_flat), .bit_cnt(bit_cnt),
        .miso(spi_miso), .pins(pins), .busy(busy_w), .rx_flat(rx_flat)
    );

    assign spi_cs_n = pins.cs_n;
    assign spi_sck  = pins.sck;
    assign spi_mosi = pins.mosi;
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cs_n,
    input logic sck,
    input logic mosi
);
    // R5: clock idles low outside a transfer
    a_r5_sck_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R5: data only moves together with a falling clock
    a_r5_mosi_stable: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sck) |-> $stable(mosi));

    // R3: SCK toggles every cycle while selected
    a_r3_sck_toggle: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> (sck != $past(sck)));

    // R7: completion only after select has been high a full cycle
    a_r7_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cs_n && $past(cs_n)));

    // R8: select only falls when leaving idle
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(!busy));
endmodule

bind spi_cmd_shifter spi_cmd_chk chk_i (
    .clk(clk), .rst(rst), .busy(busy_w),
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi)
);

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    spi_cmd_shifter dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // slave model and wire monitor
    logic [31:0]  cur_seed = '0;
    int           sl_idx = 0;
    int           cap_n = 0;
    int           cs_falls = 0;
    int           sck_while_hi = 0;
    logic [127:0] mosi_cap = '0;

    always @(negedge spi_sck) begin
        sl_idx = sl_idx + 1;
        spi_miso = cur_seed[sl_idx % 32];
    end

    always @(posedge spi_sck) begin
        if (cap_n < 128) mosi_cap[cap_n] = spi_mosi;
        cap_n = cap_n + 1;
        if (spi_cs_n) sck_while_hi = sck_while_hi + 1;
    end

    always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // poll until the start bit clears; counts cycles and gap cycles
    task automatic wait_done(output int cycles, output int gap);
        cycles = 0; gap = 0;
        rd_addr = 5'd7;
        forever begin
            @(negedge clk);
            #1;
            if (rd_data[0] == 1'b0) break;
            if (spi_cs_n) gap++; else gap = 0;
            cycles++;
            if (cycles > 2000) break;
        end
    endtask

    task automatic prep(input logic [47:0] bank, input logic [7:0] n, input logic [31:0] seed);
        for (int i = 0; i < 6; i++) wr(5'(i), bank[8*i +: 8]);
        wr(5'd6, n);
        cur_seed = seed; sl_idx = 0; spi_miso = seed[0];
        cap_n = 0; cs_falls = 0; sck_while_hi = 0; mosi_cap = '0;
    endtask

    // vector: {bank[47:0] (index5 in top byte), bit count, miso seed}
    localparam logic [87:0] VEC [6] = '{
        {48'h9F0000000000, 8'd32,  32'hA5C3_9E17},
        {48'h031234560000, 8'd48,  32'h0F0F_3355},
        {48'h02ABCDEF5AA5, 8'd48,  32'h1234_5678},
        {48'h060000000000, 8'd8,   32'hFFFF_0000},
        {48'h0B00100000C7, 8'd128, 32'hDEAD_BEEF},
        {48'h75E1000000FF, 8'd13,  32'h6B2D_91C4}
    };

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        int          cyc, gap;
        logic [127:0] exp_m;
        logic [79:0]  exp_rx, got_rx;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        @(negedge clk);
        chk("R2 reset cs_n/sck", {spi_cs_n, spi_sck}, 2'b10);
        rd(5'd7, d); chk("R2 reset cmd", d, 8'h00);
        // R1 reset value of bank and count
        for (int i = 0; i < 7; i++) begin
            rd(5'(i), d); chk("R1 reset reg", d, 8'h00);
        end
        // R1 readback
        for (int i = 0; i < 6; i++) wr(5'(i), 8'(8'h31 + 8'(i * 17)));
        for (int i = 0; i < 6; i++) begin
            rd(5'(i), d); chk("R1 readback", d, 8'(8'h31 + 8'(i * 17)));
        end

        // vector table
        for (int v = 0; v < 6; v++) begin
            logic [47:0] bank;
            logic [7:0]  n;
            logic [31:0] seed;
            {bank, n, seed} = VEC[v];
            prep(bank, n, seed);
            wr(5'd7, 8'h01);
            rd(5'd7, d); chk("R2 busy during xfer", d[0], 1'b1);
            wait_done(cyc, gap);
            chk("R3 sck edge count", 128'(cap_n), 128'(n));
            chk("R3 single cs fall", 128'(cs_falls), 128'd1);
            chk("R5 no sck with cs high", 128'(sck_while_hi), 128'd0);
            chk("R7 gap at least 2", 128'(gap >= 2), 128'd1);
            exp_m = '0;
            for (int j = 0; j < 128; j++)
                if (j < int'(n) && j < 48) exp_m[j] = bank[47 - j];
            chk("R4 mosi stream", mosi_cap, exp_m);
            exp_rx = '0;
            for (int b = 0; b < 80; b++)
                if (b < int'(n)) exp_rx[b] = seed[(int'(n) - 1 - b) % 32];
            for (int k = 0; k < 10; k++) begin
                rd(5'(8 + k), d);
                got_rx[8*k +: 8] = d;
            end
            chk("R6 rx bytes", got_rx, exp_rx);
        end

        // R6 receive cleared at start: run 8 bits of zeros after a full one
        prep(48'h0, 8'd8, 32'h0);
        wr(5'd7, 8'h01);
        wait_done(cyc, gap);
        rd(5'd9, d); chk("R6 rx cleared at start", d, 8'h00);

        // R8 start while busy is ignored
        prep(48'hC3_0000000000, 8'd16, 32'h5555_5555);
        wr(5'd7, 8'h01);
        repeat (6) @(negedge clk);
        wr(5'd7, 8'h01);
        wait_done(cyc, gap);
        chk("R8 edges unchanged", 128'(cap_n), 128'd16);
        chk("R8 one cs fall", 128'(cs_falls), 128'd1);

        // R9 zero bit count
        prep(48'hFF_FFFFFFFFFF, 8'd0, 32'hFFFF_FFFF);
        wr(5'd7, 8'h01);
        wait_done(cyc, gap);
        chk("R9 no cs", 128'(cs_falls), 128'd0);
        chk("R9 no sck", 128'(cap_n), 128'd0);
        chk("R9 quick finish", 128'(cyc <= 4), 128'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule